// File: doc/BRIEF.md
# Write-Masked Control Register Bank

This block is a small bank of 32-bit control registers. The registers hold clock-control fields: a source select, a gate enable and a divider value. Each register is built, through a parameter, in one of two write styles.

A masked register keeps only 16 bits of state. On a write, the upper half of the write word acts as a per-bit enable for the lower half. Software can therefore change a single field in one bus write, with no read-modify-write. A plain register stores all 32 bits, and a write replaces the whole word.

The bus is a single-cycle request of valid, write flag, address and write data. A read answers one cycle later with a data word and a response strobe. The stored values are also driven, all the time, on a flat output that the downstream clock logic reads.

Top module: `ctrlreg_bank`

## Requirements
- R1: After reset, every register holds its parameterised default. For a masked register only the low 16 bits of that default are kept, and its bits 31:16 read as zero.
- R2: On a write to a masked register, stored bit i (0..15) takes write-data bit i when write-data bit i+16 is 1, and keeps its old value otherwise.
- R3: A write to a masked register whose write-data bits 31:16 are all zero leaves that register unchanged.
- R4: A masked register always reads, and is always driven on `ctrl_q`, with bits 31:16 equal to zero.
- R5: A write to a plain register replaces all 32 bits with the write data.
- R6: A read request (valid=1, write=0) makes `rsp_valid` high for exactly the following cycle, with `rsp_rdata` equal to the addressed register's value. `rsp_valid` is low in every other cycle.
- R7: A write changes only the addressed register, and a cycle with no write leaves every register unchanged.
- R8: In the default configuration, register 0 is masked and holds a source-select field in bits 1:0 and a divider field in bits 12:8. A masked write to either field leaves the other field intact.
- R9: `ctrl_q` carries register k in bits 32k+31:32k. The new value appears there in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register index |
| req_wdata | input | 32 | Write data; in masked registers bits 31:16 are bit enables |
| rsp_valid | output | 1 | Read data strobe, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| ctrl_q | output | NREG*32 | All stored register values, register k at bits 32k+31:32k |

## Verification
The hardest case to reach is a masked write whose enable pattern only partly overlaps a field. Here, stored bits with enable 0 must hold even when the data bit under them differs from the stored value. To reach it, the bench sweeps every single-bit enable position with data equal to the inverse of the stored bits. It then drives a sequence of pseudo-random enable and data words, each followed by a comparison against a bit-by-bit model. Back-to-back writes of the source-select and divider fields then show that each field survives the other's update.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;
  localparam int DW = 32;
  localparam int HW = 16;

  // masked merge: enable bits live in the upper half of the write word
  function automatic logic [HW-1:0] mask_merge(input logic [HW-1:0] old_v,
                                               input logic [DW-1:0] wd);
    logic [HW-1:0] en;
    en = wd[DW-1:HW];
    return (old_v & ~en) | (wd[HW-1:0] & en);
  endfunction

  // externally visible value of a masked register
  function automatic logic [DW-1:0] masked_view(input logic [HW-1:0] s);
    return {{(DW-HW){1'b0}}, s};
  endfunction
endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode #(
  parameter int NREG = 4,
  parameter int AW   = 2
) (
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  output logic [NREG-1:0] we
);
  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign we[k] = valid && write && (addr == AW'(k));
  end

  // R7: a single write strobe per request at most
  always_comb begin
    a_r7_onehot_we: assert ($onehot0(we) || $isunknown(we));
  end
endmodule

// File: rtl/ctrlreg_cell.sv
module ctrlreg_cell
  import ctrlreg_pkg::*;
#(
  parameter bit          MASKED = 1'b1,
  parameter logic [31:0] RST    = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  if (MASKED) begin : g_masked
    logic [HW-1:0] store;
    logic          zero_en;
    assign zero_en = (wdata[DW-1:HW] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n)  store <= RST[HW-1:0];
      else if (we) store <= mask_merge(store, wdata);
    end
    assign q = masked_view(store);

    a_r2_disabled_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q[HW-1:0] & ~$past(wdata[DW-1:HW])) ==
              ($past(q[HW-1:0]) & ~$past(wdata[DW-1:HW]))));
    a_r2_enabled_bits_take: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q[HW-1:0] & $past(wdata[DW-1:HW])) ==
              ($past(wdata[HW-1:0]) & $past(wdata[DW-1:HW]))));
    a_r3_zero_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (we && zero_en) |=> $stable(q));
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      q[DW-1:HW] == '0);
  end else begin : g_plain
    logic [DW-1:0] store;
    always_ff @(posedge clk) begin
      if (!rst_n)  store <= RST;
      else if (we) store <= wdata;
    end
    assign q = store;

    a_r5_full_replace: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(wdata)));
  end

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/ctrlreg_rdmux.sv
module ctrlreg_rdmux #(
  parameter int NREG = 4,
  parameter int AW   = 2
) (
  input  logic [NREG*32-1:0] flat,
  input  logic [AW-1:0]      addr,
  output logic [31:0]        sel
);
  always_comb begin
    sel = '0;
    for (int k = 0; k < NREG; k++) begin
      if (addr == AW'(k)) sel = flat[k*32 +: 32];
    end
  end
endmodule

// File: rtl/ctrlreg_bank.sv
module ctrlreg_bank
  import ctrlreg_pkg::*;
#(
  parameter int                NREG     = 4,
  parameter logic [NREG-1:0]   MASK_SEL = 4'b0101,
  parameter logic [NREG*32-1:0] RST_VALS = {32'hCAFE_0003, 32'h0000_00A5,
                                            32'h1357_9BDF, 32'h0000_4321},
  localparam int               AW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NREG*32-1:0] ctrl_q
);
  logic [NREG-1:0] we_vec;
  logic [31:0]     rd_sel;
  logic            rd_req;

  assign rd_req = req_valid && !req_write;

  ctrlreg_decode #(.NREG(NREG), .AW(AW)) u_dec (
    .valid(req_valid), .write(req_write), .addr(req_addr), .we(we_vec)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    ctrlreg_cell #(.MASKED(MASK_SEL[k]), .RST(RST_VALS[k*32 +: 32])) u_cell (
      .clk(clk), .rst_n(rst_n), .we(we_vec[k]),
      .wdata(req_wdata), .q(ctrl_q[k*32 +: 32])
    );
  end

  ctrlreg_rdmux #(.NREG(NREG), .AW(AW)) u_rd (
    .flat(ctrl_q), .addr(req_addr), .sel(rd_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_sel;
    end
  end

  a_r6_resp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  a_r6_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  a_r6_resp_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rsp_rdata == $past(rd_sel)));
endmodule

// File: tb/sim_ctrlreg_bank.sv
module sim_ctrlreg_bank;
  localparam int NREG = 4;
  localparam logic [NREG-1:0] MSEL = 4'b0101;
  localparam logic [31:0] DEF [NREG] = '{32'h0000_4321, 32'h1357_9BDF,
                                         32'h0000_00A5, 32'hCAFE_0003};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NREG*32-1:0] ctrl_q;

  int checks = 0, errors = 0;
  logic [31:0] model [NREG];

  always #10 clk = ~clk;

  ctrlreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ctrl_q(ctrl_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side model of a write, bit by bit
  task automatic model_write(input int a, input logic [31:0] d);
    if (MSEL[a]) begin
      for (int b = 0; b < 16; b++)
        if (d[b+16]) model[a][b] = d[b];
      model[a][31:16] = 16'h0;
    end else model[a] = d;
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NREG; k++) check(tag, ctrl_q[k*32 +: 32], model[k]);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'(a); req_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rvalid"}, {31'b0, rsp_valid}, 32'd1);
    check(tag, rsp_rdata, model[a]);
    @(negedge clk);
    check({tag, " rvalid drop"}, {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] d;
    for (int k = 0; k < NREG; k++)
      model[k] = MSEL[k] ? {16'h0, DEF[k][15:0]} : DEF[k];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset defaults");
    check("R6 idle no rvalid", {31'b0, rsp_valid}, 32'd0);
    for (int k = 0; k < NREG; k++) rd(k, "R1 R4 R6 read default");

    // R2: single-bit enable sweep with inverted data on masked reg 0
    for (int b = 0; b < 16; b++) begin
      d = {16'h0, ~model[0][15:0]};
      d[b+16] = 1'b1;
      wr(0, d);
      check_all("R2 R9 single-bit enable");
    end
    // R3: zero enables, all data ones and zeros
    wr(0, 32'h0000_FFFF); check_all("R3 zero enable ones");
    wr(2, 32'h0000_0000); check_all("R3 zero enable zeros");
    // pseudo-random masked and plain writes
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr(n % NREG, lfsr ^ {lfsr[15:0], lfsr[31:16]});
      check_all("R2 R5 R7 random write");
      if (n % 25 == 0) rd(n % NREG, "R4 R6 readback");
    end
    // R5: plain full replace
    wr(1, 32'hFFFF_0000); check_all("R5 plain replace");
    wr(3, 32'h8000_0001); rd(3, "R5 plain readback");
    // R4: masked ignores upper data
    wr(2, 32'hFFFF_FFFF); rd(2, "R4 masked upper zero");
    // R8: field updates on reg 0, src sel [1:0], divider [12:8]
    wr(0, 32'hFFFF_0000); // clear
    wr(0, 32'h0003_0002); check("R8 src set", ctrl_q[31:0], 32'h0000_0002);
    wr(0, 32'h1F00_1500); check("R8 div set keeps src", ctrl_q[31:0], 32'h0000_1502);
    wr(0, 32'h0003_0001); check("R8 src set keeps div", ctrl_q[31:0], 32'h0000_1501);
    wr(0, 32'h1F00_0300); check("R8 div change keeps src", ctrl_q[31:0], 32'h0000_0301);
    check_all("R7 other registers intact");
    // R7: idle cycles change nothing
    repeat (5) @(negedge clk);
    check_all("R7 idle stable");
    // R1: reset again
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NREG; k++)
      model[k] = MSEL[k] ? {16'h0, DEF[k][15:0]} : DEF[k];
    @(negedge clk);
    check_all("R1 re-reset defaults");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule